// File: doc/BRIEF.md
# ADC Result Threshold-Violation Counter

This block sits behind one ADC channel and checks every conversion result against a low and a high unsigned threshold. A 3-bit criterion code selects the test. Samples that satisfy the test are counted toward a programmed target. Counting is either consecutive, where a miss restarts the run, or cumulative, where misses are simply skipped.

A ready flag goes high when the count reaches the target. It then stays high until software pulses a clear input. The operand can be the raw conversion result or the accumulated channel value, each with its own valid strobe. Only the strobe of the selected source triggers an evaluation.

All configuration arrives on plain input ports. The live count is driven out as a status value. Both the count and the ready flag are registered, so they reflect a sample on the clock edge that captures its strobe.

Top module: `adc_window_counter`

## Requirements
- R1: Criterion code 3'b001 matches when the operand is strictly below the low threshold or strictly above the high threshold.
- R2: Criterion code 3'b010 matches when low threshold <= operand <= high threshold.
- R3: Criterion code 3'b011 matches when operand >= high threshold; code 3'b100 matches when operand <= low threshold.
- R4: Criterion codes 3'b000, 3'b101, 3'b110 and 3'b111 disable comparison: the count and the ready flag are unchanged by any sample.
- R5: With the source select at 1, only the accumulated value is evaluated, on its own strobe. With the source select at 0, only the raw result is evaluated, on its own strobe. The strobe of the unselected source has no effect.
- R6: With the count mode at 0 (consecutive), an evaluated sample that does not match sets the count to zero.
- R7: With the count mode at 1 (cumulative), an evaluated sample that does not match leaves the count unchanged.
- R8: A target of 0 or 1 means one match, and 2..1023 means that many matches. The ready flag is set on the edge where the count reaches the target. The count saturates at the target and never wraps.
- R9: Once set, the ready flag stays high until a clear pulse. The clear pulse zeroes both the count and the flag, and it takes precedence over a matching sample in the same cycle.
- R10: The synchronous reset clears the count and the flag. So does any change of the criterion code or the count mode, on the edge where the new value is first presented.
- R11: The status output shows the current count one clock edge after the evaluated sample. After reset it reads 0 with the ready flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_valid | input | 1 | Strobe for the raw conversion result |
| raw_data | input | 16 | Raw conversion result, unsigned |
| acc_valid | input | 1 | Strobe for the accumulated channel value |
| acc_data | input | 16 | Accumulated channel value, unsigned |
| src_sel | input | 1 | Operand source: 1 accumulated, 0 raw |
| thr_lo | input | 16 | Low threshold, unsigned |
| thr_hi | input | 16 | High threshold, unsigned |
| crit_mode | input | 3 | Comparison criterion code |
| cnt_mode | input | 1 | 0 consecutive counting, 1 cumulative counting |
| target | input | 10 | Match count target |
| clear_rdy | input | 1 | Pulse that clears the ready flag and the count |
| count_stat | output | 10 | Current violation count |
| rdy | output | 1 | Target-reached flag |

## Verification
Every one of the eight criterion codes is swept in both count modes. The sweep uses a fixed set of operands that sit just below, on and just above each threshold, plus the extremes. This separates strict from inclusive comparisons and shows whether a miss resets or holds the count.

Directed sequences then cover the remaining cases:
- strobes on the unselected source, to show source selection;
- targets 0, 1 and 2, to show the one-match aliasing and saturation;
- a miss after the flag is set, to show that it sticks;
- a clear in the same cycle as a match.

A long pseudo-random stream then mixes strobes, source flips, clears, resets and configuration changes. This exposes ordering errors between clear, configuration change and counting.

// File: rtl/adcw_pkg.sv
package adcw_pkg;

    localparam int unsigned DEF_DATA_W = 16;
    localparam int unsigned DEF_CNT_W  = 10;

    localparam logic [2:0] CRIT_OUTSIDE = 3'b001;
    localparam logic [2:0] CRIT_INSIDE  = 3'b010;
    localparam logic [2:0] CRIT_AT_HIGH = 3'b011;
    localparam logic [2:0] CRIT_AT_LOW  = 3'b100;

    typedef enum logic {
        CNT_CONSEC = 1'b0,
        CNT_TOTAL  = 1'b1
    } cnt_mode_e;

    typedef struct packed {
        logic live;
        logic hit;
    } cmp_result_t;

    function automatic logic crit_enabled(input logic [2:0] code);
        return (code == CRIT_OUTSIDE) || (code == CRIT_INSIDE) ||
               (code == CRIT_AT_HIGH) || (code == CRIT_AT_LOW);
    endfunction

endpackage

// File: rtl/adcw_src_mux.sv
module adcw_src_mux #(
    parameter int unsigned DATA_W = adcw_pkg::DEF_DATA_W
) (
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              acc_valid,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              src_sel,
    output logic              smp_valid,
    output logic [DATA_W-1:0] smp_data
);
    always_comb begin
        if (src_sel) begin
            smp_valid = acc_valid;
            smp_data  = acc_data;
        end else begin
            smp_valid = raw_valid;
            smp_data  = raw_data;
        end
    end
endmodule

// File: rtl/adcw_window_cmp.sv
module adcw_window_cmp
    import adcw_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [2:0]        crit,
    output cmp_result_t       res
);
    logic below_lo, above_hi, at_or_below_lo, at_or_above_hi;

    always_comb begin
        below_lo       = smp_data <  thr_lo;
        above_hi       = smp_data >  thr_hi;
        at_or_below_lo = smp_data <= thr_lo;
        at_or_above_hi = smp_data >= thr_hi;
    end

    always_comb begin
        res.live = smp_valid && crit_enabled(crit);
        unique case (crit)
            CRIT_OUTSIDE: res.hit = below_lo || above_hi;
            CRIT_INSIDE:  res.hit = !below_lo && !above_hi;
            CRIT_AT_HIGH: res.hit = at_or_above_hi;
            CRIT_AT_LOW:  res.hit = at_or_below_lo;
            default:      res.hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/adcw_hit_counter.sv
module adcw_hit_counter
    import adcw_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cmp_result_t      res,
    input  logic [2:0]       crit,
    input  cnt_mode_e        mode,
    input  logic [CNT_W-1:0] target,
    input  logic             clear_rdy,
    output logic [CNT_W-1:0] count,
    output logic             rdy
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [2:0]       crit_q;
    cnt_mode_e        mode_q;
    logic [CNT_W-1:0] eff_target;
    logic [CNT_W-1:0] count_inc;
    logic             cfg_changed;

    always_comb begin
        eff_target  = (target == '0) ? ONE : target;
        count_inc   = (count < eff_target) ? count + ONE : count;
        cfg_changed = (crit != crit_q) || (mode != mode_q);
    end

    always_ff @(posedge clk) begin
        crit_q <= crit;
        mode_q <= mode;
        if (rst || clear_rdy || cfg_changed) begin
            count <= '0;
            rdy   <= 1'b0;
        end else if (res.live) begin
            if (res.hit) begin
                count <= count_inc;
                if (count_inc >= eff_target) rdy <= 1'b1;
            end else if (mode == CNT_CONSEC) begin
                count <= '0;
            end
        end
    end
endmodule

// File: rtl/adc_window_counter.sv
module adc_window_counter
    import adcw_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned CNT_W  = DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    input  logic              acc_valid,
    input  logic [DATA_W-1:0] acc_data,
    input  logic              src_sel,
    input  logic [DATA_W-1:0] thr_lo,
    input  logic [DATA_W-1:0] thr_hi,
    input  logic [2:0]        crit_mode,
    input  logic              cnt_mode,
    input  logic [CNT_W-1:0]  target,
    input  logic              clear_rdy,
    output logic [CNT_W-1:0]  count_stat,
    output logic              rdy
);
    logic              smp_valid;
    logic [DATA_W-1:0] smp_data;
    cmp_result_t       cmp_res;

    adcw_src_mux #(.DATA_W(DATA_W)) src_i (
        .raw_valid (raw_valid),
        .raw_data  (raw_data),
        .acc_valid (acc_valid),
        .acc_data  (acc_data),
        .src_sel   (src_sel),
        .smp_valid (smp_valid),
        .smp_data  (smp_data)
    );

    adcw_window_cmp #(.DATA_W(DATA_W)) cmp_i (
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .crit      (crit_mode),
        .res       (cmp_res)
    );

    adcw_hit_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk       (clk),
        .rst       (rst),
        .res       (cmp_res),
        .crit      (crit_mode),
        .mode      (cnt_mode_e'(cnt_mode)),
        .target    (target),
        .clear_rdy (clear_rdy),
        .count     (count_stat),
        .rdy       (rdy)
    );
endmodule

// File: rtl/adc_window_counter_chk.sv
module adc_window_counter_chk #(
    parameter int unsigned CNT_W = adcw_pkg::DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       crit_mode,
    input logic             cnt_mode,
    input logic             clear_rdy,
    input logic [CNT_W-1:0] count_stat,
    input logic             rdy
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clear_rdy |=> (!rdy && count_stat == '0)); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (count_stat != $past(count_stat)) |->
        (count_stat == '0 || count_stat == CNT_W'($past(count_stat) + 1'b1))); // R8

    AST_RDY_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (count_stat != '0)); // R8

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!adcw_pkg::crit_enabled(crit_mode) && !clear_rdy &&
         crit_mode == $past(crit_mode) && cnt_mode == $past(cnt_mode))
        |=> (count_stat == $past(count_stat) && rdy == $past(rdy))); // R4

    AST_CFG_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (crit_mode != $past(crit_mode) || cnt_mode != $past(cnt_mode))
        |=> (!rdy && count_stat == '0)); // R10
endmodule

bind adc_window_counter adc_window_counter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .crit_mode  (crit_mode),
    .cnt_mode   (cnt_mode),
    .clear_rdy  (clear_rdy),
    .count_stat (count_stat),
    .rdy        (rdy)
);

// File: tb/adc_window_counter_tb_top.sv
`timescale 1ns/1ps
module adc_window_counter_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        raw_v = 1'b0, acc_v = 1'b0, src_sel = 1'b0, clr = 1'b0, cm = 1'b0;
    logic [15:0] raw_d = '0, acc_d = '0, lo = 16'd100, hi = 16'd200;
    logic [2:0]  crit = 3'd0;
    logic [9:0]  tgt = 10'd3;
    logic [9:0]  count_stat;
    logic        rdy;

    int vectors = 0;
    int fails   = 0;
    int m_cnt   = 0;
    bit m_rdy   = 1'b0;
    logic [2:0] m_pc = 3'd0;
    logic       m_pcm = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    adc_window_counter dut_i (
        .clk(clk), .rst(rst),
        .raw_valid(raw_v), .raw_data(raw_d),
        .acc_valid(acc_v), .acc_data(acc_d),
        .src_sel(src_sel), .thr_lo(lo), .thr_hi(hi),
        .crit_mode(crit), .cnt_mode(cm), .target(tgt),
        .clear_rdy(clr), .count_stat(count_stat), .rdy(rdy)
    );

    function automatic bit ref_match(input logic [2:0] c, input logic [15:0] d);
        case (c)
            3'd1: return (d < lo) || (d > hi);
            3'd2: return (d >= lo) && (d <= hi);
            3'd3: return d >= hi;
            3'd4: return d <= lo;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] pick(input int k);
        case (k % 9)
            0: return 16'd0;      1: return 16'd99;   2: return 16'd100;
            3: return 16'd101;    4: return 16'd150;  5: return 16'd199;
            6: return 16'd200;    7: return 16'd201;  default: return 16'hFFFF;
        endcase
    endfunction

    function automatic string crit_tag(input logic [2:0] c);
        case (c)
            3'd1: return "R1";
            3'd2: return "R2";
            3'd3, 3'd4: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic step(input string tag);
        int eff;
        bit v;
        logic [15:0] d;
        @(posedge clk);
        eff = (tgt == 0) ? 1 : int'(tgt);
        v = src_sel ? acc_v : raw_v;
        d = src_sel ? acc_d : raw_d;
        if (rst || clr || crit != m_pc || cm != m_pcm) begin
            m_cnt = 0;
            m_rdy = 1'b0;
        end else if (v && crit inside {3'd1, 3'd2, 3'd3, 3'd4}) begin
            if (ref_match(crit, d)) begin
                if (m_cnt < eff) m_cnt++;
                if (m_cnt >= eff) m_rdy = 1'b1;
            end else if (!cm) begin
                m_cnt = 0;
            end
        end
        m_pc  = crit;
        m_pcm = cm;
        @(negedge clk);
        vectors++;
        if (int'(count_stat) != m_cnt || rdy !== m_rdy) begin
            fails++;
            $display("FAIL %s: count=%0d rdy=%0b expected count=%0d rdy=%0b",
                     tag, count_stat, rdy, m_cnt, m_rdy);
        end
    endtask

    task automatic next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
    endtask

    initial begin
        repeat (3) step("R10 R11 reset state");
        rst = 1'b0;
        step("R11 idle after reset");

        // Sweep every criterion in both count modes over boundary operands
        for (int mode = 0; mode < 2; mode++) begin
            for (int c = 0; c < 8; c++) begin
                crit = 3'(c);
                cm   = mode[0];
                tgt  = 10'd3;
                raw_v = 1'b0;
                step("R10 config change");
                for (int k = 0; k < 9; k++) begin
                    raw_v = 1'b1;
                    raw_d = pick(k);
                    step($sformatf("%s %s sweep", crit_tag(3'(c)), mode ? "R7" : "R6"));
                end
                raw_v = 1'b0;
                step("R9 hold idle");
            end
        end

        // R5 source selection
        crit = 3'd2; cm = 1'b1; tgt = 10'd5;
        step("R10 config change");
        src_sel = 1'b0; acc_v = 1'b1; acc_d = 16'd150;
        step("R5 unselected acc strobe ignored");
        acc_v = 1'b0; src_sel = 1'b1; raw_v = 1'b1; raw_d = 16'd150;
        step("R5 unselected raw strobe ignored");
        raw_v = 1'b0; acc_v = 1'b1; acc_d = 16'd150;
        step("R5 acc strobe used");
        acc_d = 16'd50;
        step("R5 R7 acc miss holds");
        acc_v = 1'b0; src_sel = 1'b0;

        // R8 target aliasing and saturation
        tgt = 10'd0; clr = 1'b1;
        step("R9 clear");
        clr = 1'b0; raw_v = 1'b1; raw_d = 16'd120;
        step("R8 target 0 means one");
        raw_v = 1'b0; tgt = 10'd1; clr = 1'b1;
        step("R9 clear");
        clr = 1'b0; raw_v = 1'b1;
        step("R8 target 1 means one");
        raw_v = 1'b0; tgt = 10'd2; clr = 1'b1;
        step("R9 clear");
        clr = 1'b0; raw_v = 1'b1;
        repeat (4) step("R8 saturate at 2");
        raw_d = 16'd10;
        step("R9 R7 ready sticky on miss");
        cm = 1'b0;
        step("R10 mode change clears");
        raw_d = 16'd150;
        repeat (2) step("R8 reach 2 consecutive");
        raw_d = 16'd10;
        step("R9 R6 ready sticky after reset of count");
        raw_d = 16'd150; clr = 1'b1;
        step("R9 clear beats match");
        clr = 1'b0;
        step("R6 count restarts");
        raw_v = 1'b0;

        // Pseudo-random stream
        for (int i = 0; i < 4000; i++) begin
            next_rng();
            if (i % 250 == 0) begin
                crit = rng[2:0];
                cm   = rng[3];
                tgt  = 10'(rng[6:4]);
            end
            raw_v   = rng[8];
            acc_v   = rng[9];
            src_sel = rng[10];
            raw_d   = pick(int'(rng[15:12]));
            acc_d   = pick(int'(rng[19:16]));
            clr     = (rng[24:20] == 5'd0);
            rst     = (rng[31:25] == 7'd0);
            step("R11 random stream");
        end
        rst = 1'b0; clr = 1'b0; raw_v = 1'b0; acc_v = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule